// File: doc/BRIEF.md
# Processor Idle and Wake Controller

This block lets software park the processor core without stopping the rest of the chip. Software writes a one into the sleep bit of a small clock-control register. From the next cycle the block raises a registered fetch-stall line toward the core. The core holds its program counter there, so the instruction that made the write is the last one to complete. Clocks, peripherals and every piece of state keep running while the core waits.

The block compares a vector of per-source interrupt pending flags with a matching vector of enables. When any source is both pending and enabled, the block drops the stall, clears the sleep bit by itself and emits a single-cycle wake pulse. The core then fetches the instruction that follows the one that requested sleep. Masked sources never end the sleep. Software that reads the register after waking sees the bit already cleared.

Top module: `idle_wake_ctl`

## Requirements
- R1: After a synchronous reset, fetch_stall and wake_pulse are 0 and reg_rd_data reads all zeros.
- R2: A register write while not stalled with bit IDLE_POS (default bit 0) of reg_wr_data equal to 1 raises fetch_stall in the next cycle, and reg_rd_data bit IDLE_POS then reads 1.
- R3: A register write while not stalled with bit IDLE_POS equal to 0 leaves fetch_stall at 0.
- R4: While stalled, a pending source whose enable bit is 0 does not end the stall; fetch_stall stays 1 for as long as no enabled source is pending.
- R5: While stalled, if any bit of irq_pend AND irq_en is 1, fetch_stall is 0 in the next cycle and reg_rd_data bit IDLE_POS reads 0 (the bit clears itself).
- R6: wake_pulse is 1 for exactly one cycle, only in the first cycle after a stall ends, and never otherwise.
- R7: If an enabled source is already pending in the cycle the sleep bit is written, fetch_stall is high for exactly one cycle.
- R8: Register writes made while fetch_stall is 1 have no effect; a write of 0 does not end the stall.
- R9: Every bit of reg_rd_data other than IDLE_POS reads 0, and writes to those bits have no effect.
- R10: Asserting rst while stalled clears fetch_stall and the sleep bit in the next cycle without producing a wake pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Clock-control register write strobe |
| reg_wr_data | input | REG_W | Write data; bit IDLE_POS is the sleep bit |
| reg_rd_data | output | REG_W | Register read value |
| irq_pend | input | N_SRC | Per-source interrupt pending flags |
| irq_en | input | N_SRC | Per-source interrupt enables |
| fetch_stall | output | 1 | Holds the core's instruction fetch while high |
| wake_pulse | output | 1 | One-cycle pulse when the stall ends |

## Verification
The hardest case to reach is a sleep request that meets a source which is already pending and enabled in the same cycle. That case must yield a one-cycle stall. Another hard case is a write that lands while the core is supposedly frozen. The stimulus mixes random pending and enable vectors, with masked sources much more common than enabled ones, so that long sleeps occur. Directed sequences then force the same-cycle wake, a write of 0 during the stall, and a reset in mid-sleep.

// File: rtl/idle_wake_ctl.sv
module idle_wake_ctl #(
  parameter int N_SRC    = 8,
  parameter int REG_W    = 8,
  parameter int IDLE_POS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic [N_SRC-1:0] irq_pend,
  input  logic [N_SRC-1:0] irq_en,
  output logic             fetch_stall,
  output logic             wake_pulse
);

  logic idle_q, wake_q;
  logic any_wake, go_idle;

  assign any_wake = |(irq_pend & irq_en);
  assign go_idle  = !idle_q && reg_wr_en && reg_wr_data[IDLE_POS];

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= idle_q && any_wake;
      if (idle_q && any_wake) idle_q <= 1'b0;
      else if (go_idle)       idle_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rd_data           = '0;
    reg_rd_data[IDLE_POS] = idle_q;
  end

  assign fetch_stall = idle_q;
  assign wake_pulse  = wake_q;

  p_enter_r2: assert property (@(posedge clk) disable iff (rst)
    (!fetch_stall && reg_wr_en && reg_wr_data[IDLE_POS]) |=> fetch_stall);

  p_plain_write_r3: assert property (@(posedge clk) disable iff (rst)
    (!fetch_stall && reg_wr_en && !reg_wr_data[IDLE_POS]) |=> !fetch_stall);

  p_masked_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall && !(|(irq_pend & irq_en))) |=> fetch_stall);

  p_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_stall && |(irq_pend & irq_en)) |=> (!fetch_stall && !reg_rd_data[IDLE_POS] && wake_pulse));

  p_pulse_src_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_pulse) |-> $fell(fetch_stall));

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  p_rd_mirror_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(reg_rd_data) == (fetch_stall ? 1 : 0));

endmodule

// File: tb/sim_idle_wake_ctl.sv
module sim_idle_wake_ctl;
  localparam int N = 8;
  localparam int W = 8;
  localparam int P = 0;

  logic clk = 0;
  logic rst;
  logic wr_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic [N-1:0] pend, en;
  logic stall, wake;

  int checks = 0;
  int errors = 0;
  bit m_idle, m_wake;

  always #10 clk = ~clk;

  idle_wake_ctl #(.N_SRC(N), .REG_W(W), .IDLE_POS(P)) u0 (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
    .reg_rd_data(rd_data), .irq_pend(pend), .irq_en(en),
    .fetch_stall(stall), .wake_pulse(wake));

  function automatic logic [W-1:0] exp_rd(bit idle);
    logic [W-1:0] v = '0;
    v[P] = idle;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req);
    bit hit;
    @(posedge clk);
    hit = |(pend & en);
    if (rst) begin
      m_idle = 0; m_wake = 0;
    end else begin
      m_wake = m_idle && hit;
      if (m_idle && hit) m_idle = 0;
      else if (!m_idle && wr_en && wr_data[P]) m_idle = 1;
    end
    #5;
    check(stall == m_idle, req, "fetch_stall", stall, m_idle);
    check(wake == m_wake, req, "wake_pulse", wake, m_wake);
    check(rd_data == exp_rd(m_idle), req, "reg_rd_data", rd_data, exp_rd(m_idle));
    #4;
    rst = 0; wr_en = 0; wr_data = '0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    rst = 1; wr_en = 0; wr_data = '0; pend = '0; en = '0;
    #1;
    cyc("R1"); cyc("R1");

    wr_en = 1; wr_data = 8'hFE; cyc("R3");
    cyc("R3");
    wr_en = 1; wr_data = 8'hFF; cyc("R2 R9");
    pend = 8'h0F; en = 8'hF0;
    for (int i = 0; i < 4; i++) cyc("R4");
    wr_en = 1; wr_data = 8'h00; cyc("R8");
    pend = 8'h10; cyc("R5 R6");
    pend = '0; cyc("R6"); cyc("R6");

    pend = 8'h01; en = 8'h01;
    wr_en = 1; wr_data = 8'h01; cyc("R7");
    cyc("R7 R5"); cyc("R7 R6");
    pend = '0;

    wr_en = 1; wr_data = 8'h01; cyc("R2");
    cyc("R4");
    rst = 1; cyc("R10"); cyc("R10");

    for (int i = 0; i < 3000; i++) begin
      rst     = ($urandom % 200) == 0;
      wr_en   = ($urandom % 6) == 0;
      wr_data = W'($urandom);
      pend    = N'($urandom) & N'($urandom);
      en      = (($urandom % 8) == 0) ? N'($urandom) : '0;
      cyc("R2 R3 R4 R5 R6 R8 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule